// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block watches three single-cycle match pulses coming from external address comparators and walks a small state machine (State1, State2, State3) toward a Final state. Reaching Final raises a trigger that debug logic can use to halt or to stop trace capture. Each of the three intermediate states has its own 4-bit control code, loaded through a simple write port. The code decides where each match channel sends the machine. This supports an immediate trigger on any event, plain ordered sequences, and alternation checks, where the trigger fires if event A or event B occurs twice in a row.

A range-mode input lets channels 0 and 1 act as one range comparison. In that mode the sequencer ignores the channel-1 pulse. An arm input starts the sequence in State1. The trigger stays high once it is set, until the block is disarmed or reset.

Top module: `dbgseq_top`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in State1, drops the trigger and loads every control code with 4'b1111.
- R2: A write with `wr_en` high stores `wr_data` as the code of State1, State2 or State3 for `wr_sel` values 0, 1 and 2. A write with `wr_sel` of 3 changes no code.
- R3: While `arm` is low, the state is held at State1 and the trigger is low, whatever the match inputs do.
- R4: The code table gives the destination for matches on channels 0, 1 and 2, with "-" meaning no effect. 0000: Final, Final, Final. 0001: -, State2, Final. 0011: State3, Final, -. 0100: -, State2, -. 0110: State2, State2, -. 1100: Final, -, State3. 1110: State2, -, Final.
- R5: The other nine code values, and every "-" entry, leave the state unchanged when the match arrives.
- R6: If several channels match in one cycle, the lowest-numbered channel that has an entry for the current code wins. At most one transition happens per clock.
- R7: While `range_en` is high, a match on channel 1 has no effect.
- R8: `trig` rises at the same clock edge at which the state becomes Final. It then stays high while armed, and further matches do not change it.
- R9: `state_o` reports State1, State2, State3 and Final as 0, 1, 2 and 3.
- R10: A cycle with no match pulse leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control code write strobe |
| wr_sel | input | 2 | Which state's code to write (0..2) |
| wr_data | input | 4 | Code value to write |
| arm | input | 1 | Enables sequencing; low returns to State1 |
| range_en | input | 1 | Pairs channels 0 and 1 as a range; masks channel 1 |
| match | input | 3 | Match pulses, bit i is channel i |
| state_o | output | 2 | Current sequencer state |
| trig | output | 1 | Trigger, high while in Final |

## Verification
If the state register or a decoded destination is wrong, `state_o` shows it one clock after the offending match pulse. A sequence that moves wrongly but ends in the right place is still caught at the intermediate step. If the trigger flag falls out of step with the state, the mismatch between `trig` and `state_o` shows up in that same cycle. A wrong priority or a missing range mask only appears for multi-channel patterns, so every code, start state, match pattern and range setting is swept. The alternation setups are also replayed as whole event sequences.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
  localparam int CODE_W  = 4;
  localparam int NUM_CH  = 3;
  localparam int NUM_INT = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {
    ST_ONE   = 2'd0,
    ST_TWO   = 2'd1,
    ST_THREE = 2'd2,
    ST_FIN   = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic    hit;
    seq_st_t dest;
  } step_t;

  // Destination of one channel under one control code.
  function automatic step_t code_step(input logic [CODE_W-1:0] code, input int ch);
    step_t s;
    s = '{hit: 1'b0, dest: ST_ONE};
    unique case (code)
      4'b0000: s = '{1'b1, ST_FIN};
      4'b0001: if (ch == 1) s = '{1'b1, ST_TWO};
               else if (ch == 2) s = '{1'b1, ST_FIN};
      4'b0011: if (ch == 0) s = '{1'b1, ST_THREE};
               else if (ch == 1) s = '{1'b1, ST_FIN};
      4'b0100: if (ch == 1) s = '{1'b1, ST_TWO};
      4'b0110: if (ch != 2) s = '{1'b1, ST_TWO};
      4'b1100: if (ch == 0) s = '{1'b1, ST_FIN};
               else if (ch == 2) s = '{1'b1, ST_THREE};
      4'b1110: if (ch == 0) s = '{1'b1, ST_TWO};
               else if (ch == 2) s = '{1'b1, ST_FIN};
      default: s = '{1'b0, ST_ONE};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dbgseq_code_regs.sv
module dbgseq_code_regs
  import dbgseq_pkg::*;
#(
  parameter int N = NUM_INT,
  parameter int W = CODE_W,
  parameter int SW = SEL_W,
  parameter logic [W-1:0] RST_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_sel,
  input  logic [W-1:0]      wr_data,
  output logic [N-1:0][W-1:0] codes
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        codes[g] <= RST_CODE;
      else if (wr_en && (int'(wr_sel) == g))
        codes[g] <= wr_data;
    end
  end
endmodule

// File: rtl/dbgseq_pick.sv
module dbgseq_pick
  import dbgseq_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NCH-1:0]    match,
  input  logic              range_en,
  output step_t             pick
);
  logic [NCH-1:0] eff;
  step_t          per_ch [NCH];

  always_comb begin
    eff = match;
    if (range_en) eff[1] = 1'b0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign per_ch[g] = code_step(code, g);
  end

  always_comb begin
    pick = '{1'b0, ST_ONE};
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eff[i] && per_ch[i].hit) pick = per_ch[i];
    end
  end
endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
  import dbgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              arm,
  input  logic              range_en,
  input  logic [NUM_CH-1:0] match,
  output logic [1:0]        state_o,
  output logic              trig
);
  logic [NUM_INT-1:0][CODE_W-1:0] codes;
  logic [CODE_W-1:0] cur_code;
  step_t   pick;
  seq_st_t state_q, state_d;

  dbgseq_code_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .codes(codes)
  );

  always_comb begin
    case (state_q)
      ST_ONE:   cur_code = codes[0];
      ST_TWO:   cur_code = codes[1];
      ST_THREE: cur_code = codes[2];
      default:  cur_code = '1;
    endcase
  end

  dbgseq_pick u_pick (
    .code(cur_code), .match(match), .range_en(range_en), .pick(pick)
  );

  always_comb begin
    state_d = state_q;
    if (!arm)
      state_d = ST_ONE;
    else if (state_q != ST_FIN && pick.hit)
      state_d = pick.dest;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ONE;
      trig    <= 1'b0;
    end else begin
      state_q <= state_d;
      trig    <= arm && (state_d == ST_FIN);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       arm,
  input logic [2:0] match,
  input logic [1:0] state_o,
  input logic       trig
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (state_o == 2'd0 && !trig));
  p_disarm_r3: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (state_o == 2'd0 && !trig));
  p_trig_state_r8: assert property (@(posedge clk) disable iff (rst)
    trig == (state_o == 2'd3));
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (trig && arm) |=> trig);
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (arm && match == 3'b000) |=> $stable(state_o));
endmodule

bind dbgseq_top dbgseq_chk u_chk (
  .clk(clk), .rst(rst), .arm(arm), .match(match),
  .state_o(state_o), .trig(trig)
);

// File: tb/dbgseq_top_tb.sv
module dbgseq_top_tb;
  logic clk = 0, rst = 1, wr_en = 0, arm = 0, range_en = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_data = 0;
  logic [2:0] match = 0;
  logic [1:0] state_o;
  logic trig;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dbgseq_top u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .arm(arm), .range_en(range_en), .match(match),
    .state_o(state_o), .trig(trig));

  // 7 = no effect
  function automatic int dest(input logic [3:0] c, input int ch);
    int t[3];
    case (c)
      4'b0000: t = '{3, 3, 3};
      4'b0001: t = '{7, 1, 3};
      4'b0011: t = '{2, 3, 7};
      4'b0100: t = '{7, 1, 7};
      4'b0110: t = '{1, 1, 7};
      4'b1100: t = '{3, 7, 2};
      4'b1110: t = '{1, 7, 3};
      default: t = '{7, 7, 7};
    endcase
    return t[ch];
  endfunction

  function automatic int predict(input int st, input logic [3:0] c,
                                 input logic [2:0] m, input logic rg);
    for (int ch = 0; ch < 3; ch++) begin
      if (m[ch] && !(rg && ch == 1) && dest(c, ch) != 7) return dest(c, ch);
    end
    return st;
  endfunction

  task automatic chk(input string req, input int exp_st, input logic exp_tr);
    checks++;
    if (state_o != exp_st[1:0] || trig != exp_tr) begin
      errors++;
      $display("FAIL %s: state=%0d trig=%0b expected state=%0d trig=%0b",
               req, state_o, trig, exp_st, exp_tr);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    wr_en = 0; match = 0;
  endtask

  task automatic wr(input int sel, input logic [3:0] d);
    wr_en = 1; wr_sel = sel[1:0]; wr_data = d; tick();
  endtask

  task automatic pulse(input logic [2:0] m);
    match = m; tick();
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 0; arm = 1;
    chk("R1 reset state", 0, 0);
    // R1: reset codes are 1111 (undefined), so no match moves
    pulse(3'b111); chk("R1 reset code inert", 0, 0);

    // R3: disarmed ignores matches
    arm = 0; wr(0, 4'b0000); pulse(3'b111); chk("R3 disarmed", 0, 0);
    arm = 1; pulse(3'b000); chk("R10 no match", 0, 0);
    pulse(3'b010); chk("R4 code 0000 any->Final", 3, 1);
    pulse(3'b111); chk("R8 sticky trig", 3, 1);
    arm = 0; tick(); chk("R3 disarm clears", 0, 0);

    // R2: write to sel 3 changes nothing
    wr(0, 4'b1111); wr(3, 4'b0000); arm = 1;
    pulse(3'b111); chk("R2 sel3 ignored", 0, 0);

    // Exhaustive sweep: code x start state x pattern x range (R4 R5 R6 R7 R9)
    for (int st = 0; st < 3; st++)
      for (int c = 0; c < 16; c++)
        for (int m = 0; m < 8; m++)
          for (int rg = 0; rg < 2; rg++) begin
            int e;
            arm = 0; range_en = 0; tick();
            wr(0, 4'b0100); wr(1, 4'b0011); arm = 1;
            if (st >= 1) pulse(3'b010);
            if (st >= 2) pulse(3'b001);
            chk("R9 start state", st, 0);
            wr(st, c[3:0]);
            range_en = rg[0];
            pulse(m[2:0]);
            e = predict(st, c[3:0], m[2:0], rg[0]);
            chk("R4/R5/R6/R7 sweep", e, e == 3);
          end
    range_en = 0;

    // Two-comparator alternation: A=ch0 (range pair), B=ch2
    arm = 0; tick();
    wr(0, 4'b0110); wr(1, 4'b1100); wr(2, 4'b1110); range_en = 1; arm = 1;
    pulse(3'b010); chk("R7 range masks ch1", 0, 0);
    pulse(3'b011); chk("R4 A leaves State1", 1, 0);
    pulse(3'b100); chk("R4 B to State3", 2, 0);
    pulse(3'b001); chk("R4 A back to State2", 1, 0);
    pulse(3'b001); chk("R8 A twice triggers", 3, 1);
    arm = 0; tick(); arm = 1;
    pulse(3'b001); pulse(3'b100); pulse(3'b100);
    chk("R8 B twice triggers", 3, 1);
    range_en = 0;

    // Three-comparator alternation: A=ch0+ch2 same address, B=ch1
    arm = 0; tick();
    wr(0, 4'b0100); wr(1, 4'b0011); wr(2, 4'b0001); arm = 1;
    pulse(3'b010); chk("R4 B leaves State1", 1, 0);
    pulse(3'b101); chk("R6 A picks ch0", 2, 0);
    pulse(3'b010); chk("R4 B back", 1, 0);
    pulse(3'b101); pulse(3'b101); chk("R6 A twice triggers", 3, 1);
    arm = 0; tick(); arm = 1;
    pulse(3'b010); pulse(3'b010); chk("R4 B twice triggers", 3, 1);

    rst = 1; tick(); rst = 0;
    chk("R1 reset clears trig", 0, 0);
    pulse(3'b111); chk("R1 codes back to 1111", 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule